// File: doc/BRIEF.md
# Tower-Field Byte Inverter

This block returns the multiplicative inverse of a byte taken as an element of GF(2^8). The field is built as a degree-two extension of GF(16), with a normal basis at both levels. The block is meant as the nonlinear core of a byte substitution unit. The isomorphic maps to and from other field encodings, and any affine step, belong to the surrounding logic.

The inverse comes from a^-1 = a^16 · (a^17)^-1, computed in three stages. In the first stage, the Frobenius power a^16 costs nothing: with the upper nibble holding the coefficient of γ and the lower nibble the coefficient of γ^16, the power just swaps the two nibbles. The norm a^17 = h·l + (h+l)^2·β is formed directly in a 5-bit ring modulo x^5+1. In the second stage, a 32-entry table, computed at elaboration time, inverts the norm in that ring. Each pair of complementary codes stands for one GF(16) value. The third stage multiplies the inverted norm by each input half with a cyclic convolution. It then folds each 5-bit product back to a unique 4-bit normal-basis nibble. The result can leave through an optional output register.

Top module: `gf256_tower_inv`

## Requirements
- R1: For every nonzero input a, the field product of a and the output equals the one element. The one element is encoded 8'hFF: nibble 4'hF in both halves, because γ + γ^16 = 1 and β+β^2+β^4+β^8 = 1.
- R2: An input of 8'h00 gives an output of 8'h00.
- R3: The output equals the unique byte b with a·b = 1. Bits [7:4] carry the γ coefficient and bits [3:0] the γ^16 coefficient. Within a nibble, bit i carries β^(2^i), and β is a primitive fifth root of unity.
- R4: The one element 8'hFF is its own inverse.
- R5: With REG_OUT = 1, the output changes only at a rising clock edge, one cycle after the input is sampled. An input held for several cycles keeps the output constant.
- R6: While rst is high at a rising edge, the output register loads 8'h00.
- R7: Swapping the nibbles of the input swaps the nibbles of the output, because inversion commutes with the Frobenius map.
- R8: An input whose two nibbles are equal, which is an element of GF(16), gives an output whose two nibbles are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_byte | input | 8 | Operand in two-level normal basis |
| out_byte | output | 8 | Inverse in the same encoding |

## Verification
The assertions assume that the default registered build is in use. They also assume that in_byte holds a known value across each rising edge, so that each comparison relates one sampled input to the output one cycle later. The bench changes the input only at falling edges and never leaves it undriven. It sweeps every byte value, holds some values for several cycles, and asserts reset with a nonzero input, so the held-input and reset properties also see real activity.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

    localparam int NIB_W  = 4;
    localparam int RING_W = 5;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int TAB_N  = 1 << RING_W;

    typedef logic [NIB_W-1:0]  nb4_t;
    typedef logic [RING_W-1:0] ring_t;
    typedef logic [TAB_N-1:0][RING_W-1:0] inv_tab_t;

    typedef struct packed {
        nb4_t hi;   // coefficient of gamma
        nb4_t lo;   // coefficient of gamma^16
    } nb8_t;

    // Normal-basis nibble to ring code: beta^(2^i) lands on x^(2^i mod 5).
    function automatic ring_t nb_to_ring(input nb4_t n);
        ring_t r;
        r[0] = 1'b0;
        r[1] = n[0];
        r[2] = n[1];
        r[4] = n[2];
        r[3] = n[3];
        return r;
    endfunction

    // Remove the all-ones component so the code becomes unique.
    function automatic nb4_t ring_to_nb(input ring_t r);
        nb4_t n;
        n[0] = r[1] ^ r[0];
        n[1] = r[2] ^ r[0];
        n[2] = r[4] ^ r[0];
        n[3] = r[3] ^ r[0];
        return n;
    endfunction

    // Cyclic convolution modulo x^5 + 1.
    function automatic ring_t ring_mul(input ring_t a, input ring_t b);
        ring_t r;
        r = '0;
        for (int i = 0; i < RING_W; i++) begin
            for (int j = 0; j < RING_W; j++) begin
                r[(i + j) % RING_W] ^= a[i] & b[j];
            end
        end
        return r;
    endfunction

    // Squaring is the permutation x^i -> x^(2i mod 5).
    function automatic ring_t ring_sqr(input ring_t a);
        ring_t r;
        for (int i = 0; i < RING_W; i++) begin
            r[(2 * i) % RING_W] = a[i];
        end
        return r;
    endfunction

    // Multiplication by x (that is, by beta): a rotation.
    function automatic ring_t ring_rot(input ring_t a);
        return {a[RING_W-2:0], a[RING_W-1]};
    endfunction

    // Inverse table over every 5-bit code, as a^14 = a^2 * a^4 * a^8.
    function automatic inv_tab_t build_inv_tab();
        inv_tab_t t;
        for (int v = 0; v < TAB_N; v++) begin
            ring_t x, s2, s4, s8;
            x  = ring_t'(v);
            s2 = ring_sqr(x);
            s4 = ring_sqr(s2);
            s8 = ring_sqr(s4);
            t[v] = ring_mul(ring_mul(s2, s4), s8);
        end
        return t;
    endfunction

endpackage

// File: rtl/gfinv_norm.sv
module gfinv_norm
    import gfinv_pkg::*;
(
    input  ring_t h_r,
    input  ring_t l_r,
    output ring_t norm_r
);
    ring_t sum_r;
    ring_t cross_r;

    // Norm h*l + (h+l)^2 * beta; the square and the beta factor are wiring.
    assign sum_r   = h_r ^ l_r;
    assign cross_r = ring_mul(h_r, l_r);
    assign norm_r  = cross_r ^ ring_rot(ring_sqr(sum_r));
endmodule

// File: rtl/gfinv_subinv.sv
module gfinv_subinv
    import gfinv_pkg::*;
(
    input  ring_t norm_r,
    output ring_t inv_r
);
    localparam inv_tab_t INV_TAB = build_inv_tab();

    // The ring inverse is taken directly as the redundant-basis operand.
    assign inv_r = INV_TAB[norm_r];
endmodule

// File: rtl/gfinv_scale.sv
module gfinv_scale
    import gfinv_pkg::*;
(
    input  ring_t inv_r,
    input  ring_t half_r,
    output nb4_t  half_nb
);
    ring_t prod_r;

    assign prod_r  = ring_mul(inv_r, half_r);
    assign half_nb = ring_to_nb(prod_r);
endmodule

// File: rtl/gf256_tower_inv.sv
module gf256_tower_inv
    import gfinv_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [BYTE_W-1:0] out_byte
);
    localparam int HALVES = 2;

    nb8_t  a_nb;
    nb8_t  res_nb;
    ring_t h_r;
    ring_t l_r;
    ring_t norm_r;
    ring_t inv_r;
    ring_t opnd_r [HALVES];
    nb4_t  half_nb [HALVES];

    assign a_nb = nb8_t'(in_byte);
    assign h_r  = nb_to_ring(a_nb.hi);
    assign l_r  = nb_to_ring(a_nb.lo);

    gfinv_norm u_norm (
        .h_r    (h_r),
        .l_r    (l_r),
        .norm_r (norm_r)
    );

    gfinv_subinv u_subinv (
        .norm_r (norm_r),
        .inv_r  (inv_r)
    );

    // a^16 swaps the halves: the high result takes l, the low result takes h.
    assign opnd_r[0] = l_r;
    assign opnd_r[1] = h_r;

    for (genvar g = 0; g < HALVES; g++) begin : g_scale
        gfinv_scale u_scale (
            .inv_r   (inv_r),
            .half_r  (opnd_r[g]),
            .half_nb (half_nb[g])
        );
    end

    assign res_nb.hi = half_nb[0];
    assign res_nb.lo = half_nb[1];

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_byte <= '0;
            end else begin
                out_byte <= res_nb;
            end
        end
    end else begin : g_comb
        assign out_byte = res_nb;
    end
endmodule

// File: rtl/gf256_tower_inv_chk.sv
module gf256_tower_inv_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] in_byte,
    input logic [7:0] out_byte
);
    logic live;

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= 1'b0;
        end else begin
            live <= 1'b1;
        end
    end

    a_r2_zero_maps_zero: assert property (@(posedge clk) disable iff (rst)
        (in_byte == 8'h00) |=> (out_byte == 8'h00));

    a_r1_nonzero_result: assert property (@(posedge clk) disable iff (rst)
        (in_byte != 8'h00) |=> (out_byte != 8'h00));

    a_r4_one_fixed: assert property (@(posedge clk) disable iff (rst)
        (in_byte == 8'hFF) |=> (out_byte == 8'hFF));

    a_r8_subfield_closed: assert property (@(posedge clk) disable iff (rst)
        (in_byte[7:4] == in_byte[3:0]) |=> (out_byte[7:4] == out_byte[3:0]));

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (live && (in_byte == $past(in_byte))) |=> $stable(out_byte));
endmodule

bind gf256_tower_inv gf256_tower_inv_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_byte  (in_byte),
    .out_byte (out_byte)
);

// File: tb/gf256_tower_inv_bench.sv
module gf256_tower_inv_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_byte = 8'h00;
    logic [7:0] out_byte;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] results [256];

    always #10 clk = ~clk;

    gf256_tower_inv u_gf256_tower_inv (
        .clk      (clk),
        .rst      (rst),
        .in_byte  (in_byte),
        .out_byte (out_byte)
    );

    // Behavioural GF(16): polynomial in beta modulo x^4+x^3+x^2+x+1.
    function automatic logic [3:0] to_pb(input logic [3:0] n);
        logic [3:0] p = 4'h0;
        if (n[0]) p ^= 4'h2;
        if (n[1]) p ^= 4'h4;
        if (n[2]) p ^= 4'hF;
        if (n[3]) p ^= 4'h8;
        return p;
    endfunction

    function automatic logic [3:0] from_pb(input logic [3:0] p);
        for (int k = 0; k < 16; k++) begin
            if (to_pb(4'(k)) == p) return 4'(k);
        end
        return 4'h0;
    endfunction

    function automatic logic [3:0] pb_mul(input logic [3:0] x, input logic [3:0] y);
        logic [4:0] r = 5'h00;
        for (int i = 3; i >= 0; i--) begin
            r = r << 1;
            if (r[4]) r ^= 5'h1F;
            if (y[i]) r ^= {1'b0, x};
        end
        return r[3:0];
    endfunction

    function automatic logic [3:0] m16(input logic [3:0] x, input logic [3:0] y);
        return from_pb(pb_mul(to_pb(x), to_pb(y)));
    endfunction

    // GF(256) product: rewrite in basis {1, gamma}, with gamma^2 = gamma + beta.
    function automatic logic [7:0] mul8(input logic [7:0] a, input logic [7:0] b);
        logic [3:0] a0, a1, b0, b1, p0, p1, hh;
        a0 = a[3:0]; a1 = a[7:4] ^ a[3:0];
        b0 = b[3:0]; b1 = b[7:4] ^ b[3:0];
        hh = m16(a1, b1);
        p0 = m16(a0, b0) ^ m16(hh, 4'h1);
        p1 = m16(a0, b1) ^ m16(a1, b0) ^ hh;
        return {p0 ^ p1, p0};
    endfunction

    function automatic logic [7:0] ref_inv(input logic [7:0] a);
        for (int b = 1; b < 256; b++) begin
            if (mul8(a, 8'(b)) == 8'hFF) return 8'(b);
        end
        return 8'h00;
    endfunction

    function automatic logic [7:0] swap_n(input logic [7:0] v);
        return {v[3:0], v[7:4]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] v);
        @(negedge clk);
        in_byte = v;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] prev;
        // R6: reset clears the output even with a nonzero input present
        in_byte = 8'h5A;
        repeat (3) @(negedge clk);
        check("R6", out_byte, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        in_byte = 8'h00;
        @(negedge clk);
        check("R2", out_byte, 8'h00);

        // Full sweep: R1, R2, R3, R4, R8
        for (int v = 0; v < 256; v++) begin
            logic [7:0] a, r;
            a = 8'(v);
            apply(a);
            r = out_byte;
            results[v] = r;
            check("R3", r, ref_inv(a));
            if (a == 8'h00) check("R2", r, 8'h00);
            else            check("R1", mul8(a, r), 8'hFF);
            if (a == 8'hFF) check("R4", r, 8'hFF);
            if (a[7:4] == a[3:0]) check("R8", r[7:4] ^ r[3:0], 8'h00);
        end

        // R7: nibble swap commutes with inversion
        for (int v = 0; v < 256; v++) begin
            check("R7", results[swap_n(8'(v))], swap_n(results[v]));
        end

        // R5: latency and hold
        apply(8'h37);
        prev = out_byte;
        check("R5", prev, ref_inv(8'h37));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R5", out_byte, prev);
        end
        in_byte = 8'hC4;
        #2;
        check("R5", out_byte, prev);
        @(negedge clk);
        check("R5", out_byte, ref_inv(8'hC4));

        // R6 again: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R6", out_byte, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R3", out_byte, ref_inv(8'hC4));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule